// File: doc/BRIEF.md
# Fixed-Window Word-to-Wide-Bus Memory Bridge

This block joins a processor memory port with a fixed access time to a memory interface that uses request and acknowledge. The processor side gives a 22-bit word address, a 32-bit write word and four byte write strobes. It has no read/write line and no handshake. The bridge infers the kind of access from the strobes. A mask of all zeros means a read. Any other mask means a write with those bytes enabled. The bridge then issues one request on the memory side. That side uses a 32-bit byte address, a 64-bit data bus with byte lanes, separate read and write requests, eight byte enables and an acknowledge.

The whole block runs on one bridge clock. A one-cycle strobe marks each slow-port transaction, and the slow port runs at a quarter of the bridge rate. The processor samples its read data once a fixed window has passed: four slow-port clocks, which is sixteen bridge cycles. The memory access must finish inside that window. If the acknowledge comes too late, the bridge abandons the access. It then raises a sticky error flag and keeps presenting the last word it read.

Top module: `fixed_lat_mem_bridge`

## Requirements
- R1: After reset, both memory requests are low, `cpu_timeout` is 0 and `cpu_rdata` is 0.
- R2: A strobe with `cpu_be` equal to 4'b0000 raises only `mem_rd_req`. A strobe with any other mask raises only `mem_wr_req`. The two requests are never high together.
- R3: `mem_addr` equals the word address shifted left by two, with bits 31:24 and 1:0 at zero.
- R4: On a write, word-address bit 0 picks the lane. When it is 0, `cpu_wdata` goes to `mem_wdata[31:0]`. When it is 1, `cpu_wdata` goes to `mem_wdata[63:32]`. The other half is zero.
- R5: On a write, mask bit i drives `mem_be[i]` when the lane is low, or `mem_be[i+4]` when the lane is high. On a read, all four enables of the selected half are 1. The enables of the other half are 0.
- R6: On the acknowledge of a read, the 32-bit half of `mem_rdata` picked by word-address bit 0 goes into `cpu_rdata`. It holds there until the next read completes. Writes leave it unchanged.
- R7: Each accepted strobe raises exactly one request, on the cycle after the strobe. The request stays high until the edge at which `mem_ack` is seen and is low on the next cycle.
- R8: The window is ACCESS_CLKS × CLK_RATIO bridge cycles, 16 by default. An acknowledge seen up to 15 edges after the strobe edge completes the access.
- R9: If no acknowledge has come by that deadline, the request is dropped and `cpu_timeout` is set. `cpu_rdata` keeps its previous value. The flag stays set until reset.
- R10: A strobe that arrives while an access is in flight is ignored. The outstanding address and request are unchanged, and no second request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_stb | input | 1 | One-cycle marker of a slow-port transaction |
| cpu_word_addr | input | 22 | Word address from the processor port |
| cpu_wdata | input | 32 | Write word |
| cpu_be | input | 4 | Byte write strobes; all zero means read |
| cpu_rdata | output | 32 | Read word returned to the processor |
| cpu_timeout | output | 1 | Sticky late-acknowledge error |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 64 | Lane-steered write data |
| mem_be | output | 8 | Lane-steered byte enables |
| mem_rd_req | output | 1 | Read request, held until acknowledge |
| mem_wr_req | output | 1 | Write request, held until acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Memory read data |

## Verification
The main translation is driven from a vector table. The table mixes full-word and partial-mask writes with reads, at both even and odd word addresses and at the lowest and highest addresses. This separates lane selection from mask copying and from read-mask expansion. The bench's shadow memory then shows whether partial writes merged into the correct bytes. Memory latencies of 1 and 15 cycles bracket the acceptance window, and a latency of 16 must instead produce the timeout while the old read word is kept. A stray strobe during a long access checks that the outstanding request is left undisturbed.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;
endpackage

// File: rtl/bridge_xlate.sv
module bridge_xlate
  import bridge_pkg::*;
#(
  parameter int CPU_AW = 22,
  parameter int CPU_DW = 32,
  parameter int MEM_AW = 32,
  parameter int MEM_DW = 64
) (
  input  logic [CPU_AW-1:0]       word_addr,
  input  logic [CPU_DW-1:0]       wdata,
  input  logic [CPU_DW/8-1:0]     be,
  output kind_e                   kind,
  output logic [$clog2(MEM_DW/CPU_DW)-1:0] lane_sel,
  output logic [MEM_AW-1:0]       byte_addr,
  output logic [MEM_DW-1:0]       wide_wdata,
  output logic [MEM_DW/8-1:0]     wide_be
);
  localparam int BE_W       = CPU_DW / 8;
  localparam int LANES      = MEM_DW / CPU_DW;
  localparam int SEL_W      = $clog2(LANES);
  localparam int BYTE_SHIFT = $clog2(BE_W);

  // An empty strobe set is the only way the port signals a read.
  function automatic kind_e decode_kind(input logic [BE_W-1:0] m);
    return (m == '0) ? K_READ : K_WRITE;
  endfunction

  // Word address to byte address; upper bits fall out as zero.
  function automatic logic [MEM_AW-1:0] word_to_byte(input logic [CPU_AW-1:0] w);
    return MEM_AW'(w) << BYTE_SHIFT;
  endfunction

  assign kind      = decode_kind(be);
  assign lane_sel  = word_addr[SEL_W-1:0];
  assign byte_addr = word_to_byte(word_addr);

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    logic hit;
    assign hit = (lane_sel == SEL_W'(h));
    assign wide_wdata[h*CPU_DW +: CPU_DW] = hit ? wdata : '0;
    assign wide_be[h*BE_W +: BE_W] =
      !hit ? '0 : ((kind == K_READ) ? {BE_W{1'b1}} : be);
  end
endmodule

// File: rtl/bridge_window.sv
module bridge_window #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic deadline
);
  localparam int CW       = $clog2(WINDOW);
  localparam int LAST_CNT = WINDOW - 2;

  logic [CW-1:0] cnt;

  // cnt holds k-1 at the k-th edge after the start edge; the last edge
  // that may accept an acknowledge is edge WINDOW-1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (active && cnt != CW'(LAST_CNT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign deadline = active && (cnt == CW'(LAST_CNT));

  // R8: the deadline is a single-cycle event per access
  p_deadline_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deadline |=> !deadline);
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int CPU_DW = 32,
  parameter int CPU_AW = 22,
  parameter int MEM_AW = 32,
  parameter int MEM_DW = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_stb,
  input  kind_e                    kind_in,
  input  logic [$clog2(MEM_DW/CPU_DW)-1:0] sel_in,
  input  logic [MEM_AW-1:0]        addr_in,
  input  logic [MEM_DW-1:0]        wdata_in,
  input  logic [MEM_DW/8-1:0]      be_in,
  input  logic                     deadline,
  input  logic                     mem_ack,
  input  logic [MEM_DW-1:0]        mem_rdata,
  output logic                     accept,
  output logic                     active,
  output logic [MEM_AW-1:0]        mem_addr,
  output logic [MEM_DW-1:0]        mem_wdata,
  output logic [MEM_DW/8-1:0]      mem_be,
  output logic                     mem_rd_req,
  output logic                     mem_wr_req,
  output logic [CPU_DW-1:0]        cpu_rdata,
  output logic                     cpu_timeout
);
  localparam int LANES = MEM_DW / CPU_DW;
  localparam int SEL_W = $clog2(LANES);

  kind_e            kind_q;
  logic [SEL_W-1:0] sel_q;
  logic             complete, expire, capture, req;

  function automatic logic [CPU_DW-1:0] pick_lane(input logic [MEM_DW-1:0] d,
                                                  input logic [SEL_W-1:0] s);
    logic [CPU_DW-1:0] r;
    r = '0;
    for (int h = 0; h < LANES; h++) begin
      if (s == SEL_W'(h)) r = d[h*CPU_DW +: CPU_DW];
    end
    return r;
  endfunction

  assign active   = (kind_q != K_NONE);
  assign accept   = cpu_stb && !active;
  assign complete = active && mem_ack;
  assign expire   = active && !mem_ack && deadline;
  assign capture  = complete && (kind_q == K_READ);
  assign mem_rd_req = (kind_q == K_READ);
  assign mem_wr_req = (kind_q == K_WRITE);
  assign req      = mem_rd_req || mem_wr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= K_NONE;
      sel_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else if (accept) begin
      kind_q    <= kind_in;
      sel_q     <= sel_in;
      mem_addr  <= addr_in;
      mem_wdata <= wdata_in;
      mem_be    <= be_in;
    end else if (complete || expire) begin
      kind_q    <= K_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata   <= '0;
      cpu_timeout <= 1'b0;
    end else begin
      if (capture) cpu_rdata <= pick_lane(mem_rdata, sel_q);
      if (expire)  cpu_timeout <= 1'b1;
    end
  end

  // R2: read and write requests are exclusive
  p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));
  // R7: request held while waiting inside the window
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !mem_ack && !deadline) |=> req);
  // R7: request released after acknowledge
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mem_ack) |=> !req);
  // R7: a request only starts after a strobe
  p_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(cpu_stb));
  // R5: a read always enables a full half
  p_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> ($countones(mem_be) == MEM_DW/CPU_DW*0 + CPU_DW/8));
  // R3: no address bits above the mapped word range
  p_addr_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((mem_addr >> (CPU_AW + $clog2(CPU_DW/8))) == '0));
  // R6: read word only moves on a read acknowledge
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cpu_rdata));
  // R9: timeout flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timeout |=> cpu_timeout);
  // R10: strobe during an access leaves the address untouched
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cpu_stb) |=> $stable(mem_addr));
endmodule

// File: rtl/fixed_lat_mem_bridge.sv
module fixed_lat_mem_bridge
  import bridge_pkg::*;
#(
  parameter int CPU_AW      = 22,
  parameter int CPU_DW      = 32,
  parameter int MEM_AW      = 32,
  parameter int MEM_DW      = 64,
  parameter int ACCESS_CLKS = 4,
  parameter int CLK_RATIO   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_stb,
  input  logic [CPU_AW-1:0]     cpu_word_addr,
  input  logic [CPU_DW-1:0]     cpu_wdata,
  input  logic [CPU_DW/8-1:0]   cpu_be,
  output logic [CPU_DW-1:0]     cpu_rdata,
  output logic                  cpu_timeout,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic [MEM_DW-1:0]     mem_wdata,
  output logic [MEM_DW/8-1:0]   mem_be,
  output logic                  mem_rd_req,
  output logic                  mem_wr_req,
  input  logic                  mem_ack,
  input  logic [MEM_DW-1:0]     mem_rdata
);
  localparam int WINDOW = ACCESS_CLKS * CLK_RATIO;
  localparam int SEL_W  = $clog2(MEM_DW / CPU_DW);

  kind_e              x_kind;
  logic [SEL_W-1:0]   x_sel;
  logic [MEM_AW-1:0]  x_addr;
  logic [MEM_DW-1:0]  x_wdata;
  logic [MEM_DW/8-1:0] x_be;
  logic               accept, active, deadline;

  bridge_xlate #(
    .CPU_AW(CPU_AW), .CPU_DW(CPU_DW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
  ) u_xlate (
    .word_addr (cpu_word_addr),
    .wdata     (cpu_wdata),
    .be        (cpu_be),
    .kind      (x_kind),
    .lane_sel  (x_sel),
    .byte_addr (x_addr),
    .wide_wdata(x_wdata),
    .wide_be   (x_be)
  );

  bridge_window #(.WINDOW(WINDOW)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .active  (active),
    .deadline(deadline)
  );

  bridge_ctrl #(
    .CPU_DW(CPU_DW), .CPU_AW(CPU_AW), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_stb    (cpu_stb),
    .kind_in    (x_kind),
    .sel_in     (x_sel),
    .addr_in    (x_addr),
    .wdata_in   (x_wdata),
    .be_in      (x_be),
    .deadline   (deadline),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .accept     (accept),
    .active     (active),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .cpu_rdata  (cpu_rdata),
    .cpu_timeout(cpu_timeout)
  );
endmodule

// File: tb/fixed_lat_mem_bridge_tb.sv
module fixed_lat_mem_bridge_tb;
  localparam int WINDOW = 16;
  localparam int NV = 8;
  // {word_addr[21:0], data[31:0], be[3:0], latency[4:0]}
  localparam logic [62:0] VEC [NV] = '{
    {22'h000002, 32'h11223344, 4'hF, 5'd3},
    {22'h000003, 32'h55667788, 4'hF, 5'd1},
    {22'h000002, 32'h00000000, 4'h0, 5'd5},
    {22'h000003, 32'h00000000, 4'h0, 5'd15},
    {22'h3FFFFF, 32'hDEADBEEF, 4'h5, 5'd2},
    {22'h3FFFFF, 32'h00000000, 4'h0, 5'd4},
    {22'h2AAAAA, 32'hCAFEF00D, 4'h8, 5'd7},
    {22'h2AAAAA, 32'h00000000, 4'h0, 5'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cpu_stb = 1'b0;
  logic [21:0] cpu_word_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_timeout;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_rd_req, mem_wr_req;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  fixed_lat_mem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_stb(cpu_stb), .cpu_word_addr(cpu_word_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .cpu_timeout(cpu_timeout), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int errs = 0, checks = 0;
  logic [63:0] ram [16];
  logic [63:0] shadow [16];
  logic [31:0] last_rd = '0;
  int lat_cfg = 1, rc = 0, req_rises = 0;
  logic prev_req = 1'b0;
  bit done = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Variable-latency responder acting on the memory bus it sees
  always @(negedge clk) begin
    if (!(mem_rd_req || mem_wr_req)) begin
      rc = 0;
      mem_ack = 1'b0;
    end else if (!mem_ack) begin
      rc++;
      if (rc == lat_cfg) begin
        mem_ack = 1'b1;
        if (mem_wr_req)
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) ram[mem_addr[6:3]][b*8 +: 8] = mem_wdata[b*8 +: 8];
        mem_rdata = ram[mem_addr[6:3]];
      end
    end
    if ((mem_rd_req || mem_wr_req) && !prev_req) req_rises++;
    prev_req = mem_rd_req || mem_wr_req;
  end

  task automatic txn(input logic [21:0] w, input logic [31:0] d,
                     input logic [3:0] m, input int lat, input bit expect_late);
    logic sel;
    logic [3:0] idx;
    logic [7:0] exp_be;
    logic [63:0] exp_wd;
    sel = w[0];
    idx = w[4:1];
    lat_cfg = lat;
    req_rises = 0;
    @(negedge clk);
    cpu_stb = 1'b1; cpu_word_addr = w; cpu_wdata = d; cpu_be = m;
    @(negedge clk);
    cpu_stb = 1'b0;
    if (m == 4'h0) begin
      chk("R2 read request kind", {62'd0, mem_rd_req, mem_wr_req}, 64'd2);
      exp_be = sel ? 8'hF0 : 8'h0F;
    end else begin
      chk("R2 write request kind", {62'd0, mem_rd_req, mem_wr_req}, 64'd1);
      exp_be = sel ? {m, 4'h0} : {4'h0, m};
      exp_wd = sel ? {d, 32'h0} : {32'h0, d};
      chk("R4 write lane data", mem_wdata, exp_wd);
    end
    chk("R3 byte address", {32'd0, mem_addr}, {32'd0, 8'h00, w, 2'b00});
    chk("R5 lane byte enables", {56'd0, mem_be}, {56'd0, exp_be});
    repeat (WINDOW) @(negedge clk);
    chk("R7 request released", {63'd0, mem_rd_req || mem_wr_req}, 64'd0);
    chk("R7 single request", 64'(req_rises), 64'd1);
    if (!expect_late) begin
      if (m != 4'h0) begin
        for (int b = 0; b < 4; b++)
          if (m[b]) shadow[idx][(sel ? 32 : 0) + b*8 +: 8] = d[b*8 +: 8];
      end else begin
        last_rd = sel ? shadow[idx][63:32] : shadow[idx][31:0];
      end
    end
    chk("R6 read word to port", {32'd0, cpu_rdata}, {32'd0, last_rd});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = {32'h5A000000 + 32'(i*2+1), 32'h5A000000 + 32'(i*2)};
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 requests idle", {62'd0, mem_rd_req, mem_wr_req}, 64'd0);
    chk("R1 timeout clear", {63'd0, cpu_timeout}, 64'd0);
    chk("R1 read word zero", {32'd0, cpu_rdata}, 64'd0);

    for (int v = 0; v < NV; v++)
      txn(VEC[v][62:41], VEC[v][40:9], VEC[v][8:5], int'(VEC[v][4:0]), 1'b0);
    chk("R8 latency 15 in window, no timeout", {63'd0, cpu_timeout}, 64'd0);

    // R9/R8: latency 16 misses the window
    txn(22'h000004, 32'h0, 4'h0, 16, 1'b1);
    chk("R9 timeout raised", {63'd0, cpu_timeout}, 64'd1);
    txn(22'h000005, 32'h0, 4'h0, 2, 1'b0);
    chk("R9 timeout sticky", {63'd0, cpu_timeout}, 64'd1);

    // R10: stray strobe during an access
    lat_cfg = 8; req_rises = 0;
    @(negedge clk);
    cpu_stb = 1'b1; cpu_word_addr = 22'h000006; cpu_be = 4'h0;
    @(negedge clk);
    cpu_stb = 1'b0;
    @(negedge clk);
    cpu_stb = 1'b1; cpu_word_addr = 22'h000009; cpu_be = 4'hF;
    @(negedge clk);
    cpu_stb = 1'b0;
    chk("R10 address kept", {32'd0, mem_addr}, {32'd0, 32'h00000018});
    chk("R10 still read", {62'd0, mem_rd_req, mem_wr_req}, 64'd2);
    repeat (WINDOW) @(negedge clk);
    chk("R10 one request only", 64'(req_rises), 64'd1);
    chk("R10 read word", {32'd0, cpu_rdata}, {32'd0, shadow[3][31:0]});

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 timeout cleared by reset", {63'd0, cpu_timeout}, 64'd0);
    chk("R1 read word cleared", {32'd0, cpu_rdata}, 64'd0);
    done = 1;
    finish_run();
  end
endmodule